// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

This block watches a stream of already-filtered temperature codes, one code per strobe, each tagged with the index of the sensor it came from. Every code from an enabled sensor is compared, as an unsigned number, against a common set of programmable limits. Each comparison that trips sets a sticky status bit in the slot that belongs to that sensor. A single level interrupt is raised whenever any set status bit has its enable bit set.

Software programs the limits, the sensor enables and the interrupt enables over a simple single-cycle register bus. It reads the status register, handles the event, and writes the value it read back to the status register to clear exactly those bits. The limits are a hot level, a normal-to-hot level, a cold level, and a pair of high and low offset levels. The hot condition uses the larger of the hot and normal-to-hot levels. A normal-to-hot level left at zero counts as unset, and the cold level is used in its place.

Top module: `thm_irq_monitor`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: The five limit registers keep only the low 12 bits of a write, and the upper bits read as zero. The sensor-enable register keeps bits 3:0, and bit n enables sensor n.
- R3: A code strictly below the cold level sets the cold flag (slot bit 1) of its sensor.
- R4: A code strictly above the larger of the hot level and the effective normal-to-hot level sets both the hot flag (slot bit 0) and the normal-to-hot flag (slot bit 4) of its sensor, in the same cycle.
- R5: While the normal-to-hot register holds zero, the cold level serves as the effective normal-to-hot level.
- R6: A code strictly above the high-offset level sets slot bit 2. A code strictly below the low-offset level sets slot bit 3.
- R7: A strobe whose sensor is disabled changes no status bit.
- R8: Status bits stay set until a 1 is written to that bit of the status register (address 2). A 0 written to a status bit has no effect.
- R9: When a flag is set in the same cycle as a clear of that bit, the bit ends up set.
- R10: The interrupt is high exactly when some status bit and the bit at the same position of the interrupt-enable register (address 1, 32 bits) are both 1.
- R11: Sensor c owns status bits 5c to 5c+4. Bits 20 and up always read zero. Registers are addressed as: 0 sensor enable, 1 interrupt enable, 2 status, 3 hot, 4 normal-to-hot, 5 cold, 6 high offset, 7 low offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fv_valid | input | 1 | A filtered code is present this cycle |
| fv_chan | input | 2 | Sensor index of the code |
| fv_value | input | 12 | Filtered temperature code |
| irq | output | 1 | Level interrupt |

## Verification
A strobe or a register write is taken at one rising edge. Its effect is visible on bus_rdata and irq straight after that same edge, because status and enables are registers and both the read mux and the interrupt are combinational from them. The bench drives its inputs at the falling edge, lets exactly one rising edge pass, and reads the registers and irq at the following falling edge. Each check compares against a model that it has advanced by one step for that edge.

// File: rtl/thm_mon_pkg.sv
package thm_mon_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_SENS = 3'd0,
    REG_IEN  = 3'd1,
    REG_ISTS = 3'd2,
    REG_HOT  = 3'd3,
    REG_N2H  = 3'd4,
    REG_COLD = 3'd5,
    REG_OHI  = 3'd6,
    REG_OLO  = 3'd7
  } reg_sel_e;

  // flag positions inside one sensor slot
  localparam int F_HOT    = 0;
  localparam int F_COLD   = 1;
  localparam int F_OFS_HI = 2;
  localparam int F_OFS_LO = 3;
  localparam int F_N2H    = 4;
  localparam int SLOT_W   = 5;

  // normal-to-hot level, cold substitutes when unset
  function automatic int unsigned eff_n2h(int unsigned n2h, int unsigned cold);
    return (n2h == 0) ? cold : n2h;
  endfunction

  // effective hot level: larger of the two hot limits
  function automatic int unsigned hot_level(int unsigned hot, int unsigned n2h,
                                            int unsigned cold);
    int unsigned e;
    e = eff_n2h(n2h, cold);
    return (hot > e) ? hot : e;
  endfunction

endpackage

// File: rtl/thm_regs.sv
module thm_regs
  import thm_mon_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [NUM_CH-1:0] sens_en,
  output logic [DATA_W-1:0] irq_en,
  output logic [THR_W-1:0]  thr_hot,
  output logic [THR_W-1:0]  thr_n2h,
  output logic [THR_W-1:0]  thr_cold,
  output logic [THR_W-1:0]  thr_ohi,
  output logic [THR_W-1:0]  thr_olo,
  output logic [DATA_W-1:0] clr_mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sens_en  <= '0;
      irq_en   <= '0;
      thr_hot  <= '0;
      thr_n2h  <= '0;
      thr_cold <= '0;
      thr_ohi  <= '0;
      thr_olo  <= '0;
    end else if (bus_wr) begin
      case (reg_sel_e'(bus_addr))
        REG_SENS: sens_en  <= bus_wdata[NUM_CH-1:0];
        REG_IEN:  irq_en   <= bus_wdata;
        REG_HOT:  thr_hot  <= bus_wdata[THR_W-1:0];
        REG_N2H:  thr_n2h  <= bus_wdata[THR_W-1:0];
        REG_COLD: thr_cold <= bus_wdata[THR_W-1:0];
        REG_OHI:  thr_ohi  <= bus_wdata[THR_W-1:0];
        REG_OLO:  thr_olo  <= bus_wdata[THR_W-1:0];
        default:  ;
      endcase
    end
  end

  // write-one-to-clear request toward the status register
  assign clr_mask = (bus_wr && (reg_sel_e'(bus_addr) == REG_ISTS)) ? bus_wdata : '0;

endmodule

// File: rtl/thm_compare.sv
module thm_compare
  import thm_mon_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                      fv_valid,
  input  logic [$clog2(NUM_CH)-1:0] fv_chan,
  input  logic [THR_W-1:0]          fv_value,
  input  logic [NUM_CH-1:0]         sens_en,
  input  logic [THR_W-1:0]          thr_hot,
  input  logic [THR_W-1:0]          thr_n2h,
  input  logic [THR_W-1:0]          thr_cold,
  input  logic [THR_W-1:0]          thr_ohi,
  input  logic [THR_W-1:0]          thr_olo,
  output logic [DATA_W-1:0]         set_mask
);

  localparam int CH_W   = $clog2(NUM_CH);
  localparam int USED_W = NUM_CH * SLOT_W;

  logic [SLOT_W-1:0] flags;
  int unsigned       val_u;
  int unsigned       hot_u;

  // one code per cycle: the limit tests are shared by all sensors
  always_comb begin
    val_u = 32'(fv_value);
    hot_u = hot_level(32'(thr_hot), 32'(thr_n2h), 32'(thr_cold));
    flags = '0;
    flags[F_HOT]    = val_u > hot_u;
    flags[F_N2H]    = val_u > hot_u;
    flags[F_COLD]   = fv_value < thr_cold;
    flags[F_OFS_HI] = fv_value > thr_ohi;
    flags[F_OFS_LO] = fv_value < thr_olo;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    logic hit;
    assign hit = fv_valid && (fv_chan == CH_W'(c)) && sens_en[c];
    assign set_mask[c*SLOT_W +: SLOT_W] = hit ? flags : '0;
  end

  if (DATA_W > USED_W) begin : g_pad
    assign set_mask[DATA_W-1:USED_W] = '0;
  end

endmodule

// File: rtl/thm_status.sv
module thm_status #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [DATA_W-1:0] irq_en,
  output logic [DATA_W-1:0] sts,
  output logic              irq
);

  // a new flag outranks a clear of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_mask) | set_mask;
  end

  assign irq = |(sts & irq_en);

endmodule

// File: rtl/thm_irq_monitor.sv
module thm_irq_monitor
  import thm_mon_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [REG_AW-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      fv_valid,
  input  logic [$clog2(NUM_CH)-1:0] fv_chan,
  input  logic [THR_W-1:0]          fv_value,
  output logic                      irq
);

  logic [NUM_CH-1:0] sens_en;
  logic [DATA_W-1:0] irq_en;
  logic [THR_W-1:0]  thr_hot, thr_n2h, thr_cold, thr_ohi, thr_olo;
  logic [DATA_W-1:0] clr_mask;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] sts;

  thm_regs #(.THR_W(THR_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sens_en(sens_en), .irq_en(irq_en),
    .thr_hot(thr_hot), .thr_n2h(thr_n2h), .thr_cold(thr_cold),
    .thr_ohi(thr_ohi), .thr_olo(thr_olo), .clr_mask(clr_mask)
  );

  thm_compare #(.THR_W(THR_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_cmp (
    .fv_valid(fv_valid), .fv_chan(fv_chan), .fv_value(fv_value),
    .sens_en(sens_en), .thr_hot(thr_hot), .thr_n2h(thr_n2h),
    .thr_cold(thr_cold), .thr_ohi(thr_ohi), .thr_olo(thr_olo),
    .set_mask(set_mask)
  );

  thm_status #(.DATA_W(DATA_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .irq_en(irq_en), .sts(sts), .irq(irq)
  );

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_SENS: bus_rdata = DATA_W'(sens_en);
      REG_IEN:  bus_rdata = irq_en;
      REG_ISTS: bus_rdata = sts;
      REG_HOT:  bus_rdata = DATA_W'(thr_hot);
      REG_N2H:  bus_rdata = DATA_W'(thr_n2h);
      REG_COLD: bus_rdata = DATA_W'(thr_cold);
      REG_OHI:  bus_rdata = DATA_W'(thr_ohi);
      default:  bus_rdata = DATA_W'(thr_olo);
    endcase
  end

endmodule

// File: rtl/thm_irq_monitor_chk.sv
module thm_irq_monitor_chk
  import thm_mon_pkg::*;
#(
  parameter int THR_W  = 12,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [REG_AW-1:0]         bus_addr,
  input logic                      fv_valid,
  input logic [$clog2(NUM_CH)-1:0] fv_chan,
  input logic [THR_W-1:0]          fv_value,
  input logic                      irq,
  input logic [NUM_CH-1:0]         sens_en,
  input logic [DATA_W-1:0]         irq_en,
  input logic [THR_W-1:0]          thr_cold,
  input logic [DATA_W-1:0]         set_mask,
  input logic [DATA_W-1:0]         sts
);

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fv_valid && !sens_en[fv_chan]) |-> (set_mask == '0));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == REG_ISTS)) |=> ((sts & $past(sts)) == $past(sts)));

  a_r9_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((sts & $past(set_mask)) == $past(set_mask)));

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

  a_r3_cold_below: assert property (@(posedge clk) disable iff (!rst_n)
    (fv_valid && set_mask[SLOT_W*int'(fv_chan) + F_COLD]) |-> (fv_value < thr_cold));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pair
    a_r4_hot_pair: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[c*SLOT_W + F_HOT] == set_mask[c*SLOT_W + F_N2H]);
  end

endmodule

bind thm_irq_monitor thm_irq_monitor_chk #(
  .THR_W(THR_W), .NUM_CH(NUM_CH), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .fv_valid(fv_valid), .fv_chan(fv_chan), .fv_value(fv_value), .irq(irq),
  .sens_en(sens_en), .irq_en(irq_en), .thr_cold(thr_cold),
  .set_mask(set_mask), .sts(sts)
);

// File: tb/test_thm_irq_monitor.sv
`timescale 1ns/1ps
module test_thm_irq_monitor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fv_valid = 1'b0;
  logic [1:0]  fv_chan = '0;
  logic [11:0] fv_value = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  // bench model of the programmable state
  logic [3:0]  m_sens;
  logic [31:0] m_ien;
  logic [11:0] m_hot, m_n2h, m_cold, m_ohi, m_olo;
  logic [31:0] m_sts;

  always #4 clk = ~clk;

  thm_irq_monitor i_thm_irq_monitor (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fv_valid(fv_valid),
    .fv_chan(fv_chan), .fv_value(fv_value), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flags expected for one code, restated from the requirements
  function automatic logic [31:0] exp_flags(int ch, int v);
    int lvl;
    int base;
    logic [31:0] r;
    r = '0;
    if (m_sens[ch] == 1'b0) return r;
    base = 5 * ch;
    lvl = int'(m_cold);
    if (m_n2h != 0) lvl = int'(m_n2h);
    if (int'(m_hot) > lvl) lvl = int'(m_hot);
    if (v > lvl) begin r[base] = 1'b1; r[base+4] = 1'b1; end
    if (v < int'(m_cold)) r[base+1] = 1'b1;
    if (v > int'(m_ohi))  r[base+2] = 1'b1;
    if (v < int'(m_olo))  r[base+3] = 1'b1;
    return r;
  endfunction

  task automatic model_write(int a, logic [31:0] d);
    case (a)
      0: m_sens = d[3:0];
      1: m_ien  = d;
      3: m_hot  = d[11:0];
      4: m_n2h  = d[11:0];
      5: m_cold = d[11:0];
      6: m_ohi  = d[11:0];
      7: m_olo  = d[11:0];
      default: ;
    endcase
  endtask

  // one clock step, entered and left at a falling edge
  task automatic step(bit w, int a, logic [31:0] d, bit v, int ch, int val);
    logic [31:0] s, clr;
    bus_wr = w; bus_addr = a[2:0]; bus_wdata = d;
    fv_valid = v; fv_chan = ch[1:0]; fv_value = val[11:0];
    s   = v ? exp_flags(ch, val) : 32'h0;
    clr = (w && a == 2) ? d : 32'h0;
    @(posedge clk);
    @(negedge clk);
    m_sts = (m_sts & ~clr) | s;
    if (w) model_write(a, d);
    bus_wr = 1'b0; fv_valid = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] q);
    bus_addr = a[2:0];
    #1;
    q = bus_rdata;
  endtask

  task automatic check_state(string tag);
    logic [31:0] q;
    rd(2, q);
    check({tag, " status"}, q, m_sts);
    check({tag, " irq"}, {31'b0, irq}, {31'b0, |(m_sts & m_ien)});
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] q;
    void'($urandom(32'd20240611));
    m_sens = '0; m_ien = '0; m_hot = '0; m_n2h = '0;
    m_cold = '0; m_ohi = '0; m_olo = '0; m_sts = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    for (int a = 0; a < 8; a++) begin
      rd(a, q);
      check("R1 reset register", q, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: field widths
    step(1, 3, 32'hFFFF_FFFF, 0, 0, 0);
    rd(3, q); check("R2 limit width", q, 32'h0000_0FFF);
    step(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    rd(0, q); check("R2 enable width", q, 32'h0000_000F);

    // directed setup: only sensor 0 on
    step(1, 0, 32'h1, 0, 0, 0);
    step(1, 5, 32'd100, 0, 0, 0);
    step(1, 3, 32'd800, 0, 0, 0);
    step(1, 4, 32'd900, 0, 0, 0);
    step(1, 6, 32'd600, 0, 0, 0);
    step(1, 7, 32'd200, 0, 0, 0);
    step(1, 1, 32'h0, 0, 0, 0);

    // R3 + R6: code 50 is below cold and below low offset
    step(0, 0, 0, 1, 0, 50);
    rd(2, q); check("R3 R6 cold and low-offset flags", q, 32'h0000_000A);
    check("R10 all masked", {31'b0, irq}, 32'h0);
    step(1, 1, 32'h2, 0, 0, 0);
    check("R10 enabled cold flag", {31'b0, irq}, 32'h1);
    // R8: clear one bit, then a zero write
    step(1, 2, 32'h2, 0, 0, 0);
    rd(2, q); check("R8 w1c one bit", q, 32'h0000_0008);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);
    step(1, 2, 32'h0, 0, 0, 0);
    rd(2, q); check("R8 zero write keeps", q, 32'h0000_0008);
    // R4: 850 is above hot but not above normal-to-hot
    step(0, 0, 0, 1, 0, 850);
    rd(2, q); check("R4 larger level governs", q, 32'h0000_000C);
    step(0, 0, 0, 1, 0, 901);
    rd(2, q); check("R4 hot pair", q, 32'h0000_001D);

    // R5: unset normal-to-hot takes the cold level
    step(1, 2, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 4, 32'h0, 0, 0, 0);
    step(1, 3, 32'd50, 0, 0, 0);
    step(0, 0, 0, 1, 0, 80);
    rd(2, q); check("R5 cold substitutes, no hot", q, 32'h0000_000A);
    step(0, 0, 0, 1, 0, 120);
    rd(2, q); check("R5 above substituted level", q, 32'h0000_001B);

    // R7: disabled sensor 1
    step(0, 0, 0, 1, 1, 4000);
    rd(2, q); check("R7 disabled sensor ignored", q, 32'h0000_001B);

    // R11: sensor 2 slot
    step(1, 2, 32'hFFFF_FFFF, 0, 0, 0);
    step(1, 0, 32'h5, 0, 0, 0);
    step(0, 0, 0, 1, 2, 4000);
    rd(2, q); check("R11 sensor 2 slot", q, 32'h0000_5400);

    // R9: flag and clear of the same bits in one cycle
    step(1, 2, 32'hFFFF_FFFF, 1, 2, 4000);
    rd(2, q); check("R9 set wins over clear", q, 32'h0000_5400);

    check_state("R8 R10 directed model");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2, 3: step(0, 0, 0, 1, $urandom_range(0, 3), $urandom_range(0, 4095));
        4: step(1, $urandom_range(3, 7), $urandom_range(0, 4095), 0, 0, 0);
        5: step(1, 4, ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(0, 4095), 0, 0, 0);
        6: step(1, 2, $urandom, 0, 0, 0);
        7: step(1, 1, $urandom, 0, 0, 0);
        8: step(1, 0, $urandom_range(0, 15), 0, 0, 0);
        default: step(1, 2, $urandom, 1, $urandom_range(0, 3), $urandom_range(0, 4095));
      endcase
      check_state("R4 R8 R9 R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule